// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This unit is the address-recognition front end of an I2C target. It samples the serial clock and data lines through a synchronizer. It shifts in the first byte after a START condition, or the first two bytes when 10-bit addressing is selected. It then compares the received address with a programmed own address. A per-bit mask can turn chosen address bits into don't-care positions. The mask comes either from a coarse five-control scheme or from a full 8-bit mask word. An all-zero first byte is the general call, and the unit answers it only when this is enabled.

When the address is accepted, the unit pulls SDA low for the acknowledge pulse. Before that acknowledge it raises a one-cycle match interrupt, together with a general-call flag and the transfer direction. If stretching is enabled, it then holds SCL low until a software clear pulse arrives. A repeated START or a STOP abandons any partial reception. Data bytes after the address are handled elsewhere.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for a START.
- `ST_RECV`: shifts address bits on rising SCL.
- `ST_ACK_SETUP`: waits for the falling SCL edge that opens the acknowledge slot.
- `ST_ACK_DRIVE`: pulls SDA low through the ninth pulse.
- `ST_STRETCH`: holds SCL low.
- `ST_ATTACHED`: the address was accepted and the unit now waits.
- `ST_IGNORE`: the address was rejected and the unit now waits.

Its transitions are:
- IDLE→RECV on START.
- RECV→ACK_SETUP on an accepted byte, and RECV→IGNORE on a rejected byte.
- ACK_SETUP→ACK_DRIVE on SCL fall.
- ACK_DRIVE→RECV after a 10-bit header.
- ACK_DRIVE→STRETCH or ACK_DRIVE→ATTACHED after the final acknowledge, depending on the stretch enable.
- STRETCH→ATTACHED on the clear pulse.
- Any state→RECV on START, and any state→IDLE on STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: In 7-bit mode, received bits 7:1 are compared with `own_addr[7:1]`, and received bit 0 is latched as the direction, where 1 means read. It is never compared. On a match, SDA is pulled low during the ninth SCL pulse.
- R2: An all-zero first byte is accepted with ACK, an interrupt and `gcall_hit`=1 only when `gcall_en`=1. When `gcall_en`=0 it is rejected, whatever the mask says.
- R3: With `full_mask_mode`=1, a set bit i of `full_mask` makes address bit i a don't-care. Bit 0 of the mask acts only on the second byte in 10-bit mode.
- R4: With `full_mask_mode`=0, `coarse_mask[4:1]` masks address bits 5:2, one bit each. Address bits 7:6 are never masked in this mode.
- R5: With `full_mask_mode`=0, `coarse_mask[0]` masks address bit 1 in 7-bit mode, and address bits 1:0 in 10-bit mode.
- R6: In 10-bit mode, the first byte must be 11110, then `own_addr[9:8]`, then the direction bit. Such a header is acknowledged without an interrupt. The interrupt and final ACK come only after the second byte matches `own_addr[7:0]` under the mask.
- R7: A rejected byte gets no ACK and no interrupt. Later bytes are ignored until the next START.
- R8: A repeated START restarts reception from bit 7. A STOP returns to idle, so later bits without a START get no ACK.
- R9: With `stretch_en`=1, SCL is held low after the final acknowledge, for both read and write addresses. With `stretch_en`=0, SCL is never held.
- R10: A one-cycle `stretch_clr` releases SCL at the next clock.
- R11: During and after reset, `sda_pull`, `scl_pull` and `match_irq` are 0.
- R12: `match_irq` is a single-cycle pulse. `gcall_hit` and `rw_dir` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| own_addr | input | 10 | Own address (bits 7:1 used in 7-bit mode) |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| full_mask_mode | input | 1 | 1 selects the 8-bit mask word, 0 the coarse controls |
| coarse_mask | input | 5 | Coarse mask controls (see R4, R5) |
| full_mask | input | 8 | Full mask word |
| gcall_en | input | 1 | General-call answer enable |
| stretch_en | input | 1 | Clock-stretch enable |
| stretch_clr | input | 1 | Pulse that releases a held SCL |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| scl_pull | output | 1 | 1 pulls SCL low (stretch) |
| match_irq | output | 1 | One-cycle address match pulse |
| gcall_hit | output | 1 | Current match is a general call |
| rw_dir | output | 1 | Latched direction bit, 1 means read |

## Verification
The bench builds the unit with a three-stage synchronizer rather than the default two. This puts an extra cycle between each bus edge and the state machine, while the bus quarter-period stays at eight clocks. It therefore shows that acknowledge timing, stretch entry and START/STOP detection depend on synchronized edges and not on a fixed latency. Mode and mask inputs are ports, so one build covers 7-bit and 10-bit addressing, both mask schemes and the general-call gate.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK_SETUP,
        ST_ACK_DRIVE,
        ST_STRETCH,
        ST_ATTACHED,
        ST_IGNORE
    } am_state_e;

    // Leading pattern of a 10-bit address header byte
    localparam logic [4:0] TEN_TAG = 5'b11110;

endpackage

// File: rtl/i2c_am_bus_edge.sv
module i2c_am_bus_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_s, scl_q, sda_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
                    sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_i;
                    sda_sync <= sda_i;
                end
            end
        end
    endgenerate

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_am_addr_cmp.sv
module i2c_am_addr_cmp #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] own_lo,
    input  logic              ten_bit,
    input  logic              full_mode,
    input  logic [4:0]        coarse,
    input  logic [BYTE_W-1:0] full,
    output logic              hit
);
    logic [BYTE_W-1:0] eff_mask;
    logic [BYTE_W-1:0] bit_ok;

    // Coarse scheme: bits 7:6 exact, 5:2 one control each, bit 1 shared
    // with bit 0 only when ten-bit addressing is active.
    always_comb begin
        if (full_mode) begin
            eff_mask = full;
        end else begin
            eff_mask = '0;
            eff_mask[5:2] = coarse[4:1];
            eff_mask[1]   = coarse[0];
            eff_mask[0]   = ten_bit & coarse[0];
        end
    end

    genvar i;
    generate
        for (i = 0; i < BYTE_W; i++) begin : g_bit
            assign bit_ok[i] = eff_mask[i] | (rx_byte[i] == own_lo[i]);
        end
    endgenerate

    // In 7-bit mode bit 0 carries the direction and is never compared
    assign hit = (&bit_ok[BYTE_W-1:1]) & (bit_ok[0] | ~ten_bit);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [9:0] own_addr,
    input  logic       ten_bit_mode,
    input  logic       full_mask_mode,
    input  logic [4:0] coarse_mask,
    input  logic [7:0] full_mask,
    input  logic       gcall_en,
    input  logic       stretch_en,
    input  logic       stretch_clr,
    output logic       sda_pull,
    output logic       scl_pull,
    output logic       match_irq,
    output logic       gcall_hit,
    output logic       rw_dir
);
    import i2c_am_pkg::*;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    am_state_e state_q, state_d;

    logic scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] shift_q, rx_byte;
    logic second_q, final_q, irq_q, gc_q, rw_q;
    logic cmp_hit, byte_done, gc_byte, hdr_ok, accept, final_dec;

    i2c_am_bus_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
    );

    assign rx_byte = {shift_q[BYTE_W-2:0], sda_s};

    i2c_am_addr_cmp #(.BYTE_W(BYTE_W)) u_cmp (
        .rx_byte(rx_byte), .own_lo(own_addr[7:0]), .ten_bit(ten_bit_mode),
        .full_mode(full_mask_mode), .coarse(coarse_mask), .full(full_mask),
        .hit(cmp_hit)
    );

    assign byte_done = (state_q == ST_RECV) && scl_rise && (bit_cnt_q == LAST_BIT);
    assign gc_byte   = !second_q && (rx_byte == '0);
    assign hdr_ok    = (rx_byte[7:3] == TEN_TAG) && (rx_byte[2:1] == own_addr[9:8]);

    // Byte verdict: accept and whether it completes the address
    always_comb begin
        if (second_q) begin
            accept = cmp_hit;      final_dec = 1'b1;
        end else if (gc_byte) begin
            accept = gcall_en;     final_dec = 1'b1;
        end else if (ten_bit_mode) begin
            accept = hdr_ok;       final_dec = 1'b0;
        end else begin
            accept = cmp_hit;      final_dec = 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_RECV;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_RECV:      if (byte_done) state_d = accept ? ST_ACK_SETUP : ST_IGNORE;
                ST_ACK_SETUP: if (scl_fall) state_d = ST_ACK_DRIVE;
                ST_ACK_DRIVE: if (scl_fall) begin
                                  if (!final_q)        state_d = ST_RECV;
                                  else if (stretch_en) state_d = ST_STRETCH;
                                  else                 state_d = ST_ATTACHED;
                              end
                ST_STRETCH:   if (stretch_clr) state_d = ST_ATTACHED;
                ST_ATTACHED:  state_d = ST_ATTACHED;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
            second_q  <= 1'b0;
            final_q   <= 1'b0;
            irq_q     <= 1'b0;
            gc_q      <= 1'b0;
            rw_q      <= 1'b0;
        end else begin
            irq_q <= byte_done && accept && final_dec && !start_det && !stop_det;
            if (start_det || stop_det) begin
                bit_cnt_q <= '0;
                second_q  <= 1'b0;
                final_q   <= 1'b0;
                gc_q      <= 1'b0;
            end else begin
                if (state_q == ST_RECV && scl_rise) begin
                    shift_q   <= rx_byte;
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
                if (byte_done) begin
                    final_q <= final_dec;
                    if (!second_q) rw_q <= rx_byte[0];
                    if (accept && final_dec && gc_byte) gc_q <= 1'b1;
                end
                if (state_q == ST_ACK_DRIVE && scl_fall && !final_q) second_q <= 1'b1;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        sda_pull = 1'b0;
        scl_pull = 1'b0;
        unique case (state_q)
            ST_ACK_DRIVE: sda_pull = 1'b1;
            ST_STRETCH:   scl_pull = 1'b1;
            default:      ;
        endcase
    end

    assign match_irq = irq_q;
    assign gcall_hit = gc_q;
    assign rw_dir    = rw_q;

    // Assertions
    assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |=> !match_irq);

    assert_gcall_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gcall_hit) |-> $past(gcall_en));

    assert_stretch_only_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> $past(stretch_en));

    assert_stretch_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && stretch_clr) |=> !scl_pull);

    assert_stop_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_pull && !scl_pull));

endmodule

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_line, sda_line;
    logic [9:0] own_addr = 10'h052;
    logic ten_bit_mode = 1'b0, full_mask_mode = 1'b1;
    logic [4:0] coarse_mask = '0;
    logic [7:0] full_mask = '0;
    logic gcall_en = 1'b0, stretch_en = 1'b0, stretch_clr = 1'b0;
    logic sda_pull, scl_pull, match_irq, gcall_hit, rw_dir;

    int tests = 0;
    int fails = 0;
    logic [1:0] exp_q[$];

    always #10 clk = ~clk;

    assign scl_line = scl_m & ~scl_pull;
    assign sda_line = sda_m & ~sda_pull;

    i2c_addr_match #(.SYNC_STAGES(3)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .own_addr(own_addr), .ten_bit_mode(ten_bit_mode),
        .full_mask_mode(full_mask_mode), .coarse_mask(coarse_mask),
        .full_mask(full_mask), .gcall_en(gcall_en), .stretch_en(stretch_en),
        .stretch_clr(stretch_clr), .sda_pull(sda_pull), .scl_pull(scl_pull),
        .match_irq(match_irq), .gcall_hit(gcall_hit), .rw_dir(rw_dir)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic read_ack(output logic got);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        got = ~sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic got);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        read_ack(got);
    endtask

    task automatic xfer7(input logic [7:0] b, input logic ack_e, input logic irq_e,
                         input logic gc_e, input string tag);
        logic got;
        i2c_start();
        if (irq_e) exp_q.push_back({gc_e, b[0]});
        send_byte(b, got);
        chk(tag, got, ack_e);
        i2c_stop();
        chk({tag, " irq pending"}, exp_q.size(), 0);
    endtask

    task automatic xfer10(input logic [7:0] b1, input logic [7:0] b2, input logic a1,
                          input logic a2, input string tag);
        logic got;
        i2c_start();
        if (a1 && a2) exp_q.push_back({1'b0, b1[0]});
        send_byte(b1, got);
        chk({tag, " header"}, got, a1);
        if (a1) begin
            send_byte(b2, got);
            chk({tag, " second"}, got, a2);
        end
        i2c_stop();
        chk({tag, " irq pending"}, exp_q.size(), 0);
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Scoreboard monitor: every interrupt must be expected (R12, R7)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && match_irq) begin
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected match interrupt", 1, 0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    chk("R12 flags at interrupt {gc,dir}", {gcall_hit, rw_dir}, e);
                end
                @(negedge clk);
                chk("R12 interrupt width", match_irq, 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic got;
        repeat (3) @(negedge clk);
        chk("R11 reset sda_pull", sda_pull, 0);
        chk("R11 reset scl_pull", scl_pull, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 after reset irq", match_irq, 0);
        chk("R11 after reset scl_pull", scl_pull, 0);

        // R1 7-bit exact, write and read
        xfer7(8'h52, 1, 1, 0, "R1 write match");
        xfer7(8'h53, 1, 1, 0, "R1 read match");
        own_addr = 10'h053;
        xfer7(8'h52, 1, 1, 0, "R1 own bit0 not compared");
        own_addr = 10'h052;

        // R7 mismatch then ignored byte in same transfer
        i2c_start();
        send_byte(8'h56, got);
        chk("R7 mismatch no ack", got, 0);
        send_byte(8'h52, got);
        chk("R7 later byte ignored", got, 0);
        i2c_stop();

        // R3 full mask
        full_mask = 8'h04;
        xfer7(8'h56, 1, 1, 0, "R3 masked bit2");
        full_mask = 8'h00;

        // R4 / R5 coarse mask in 7-bit
        full_mask_mode = 1'b0;
        coarse_mask = 5'b00100;
        xfer7(8'h5A, 1, 1, 0, "R4 coarse masks bit3");
        coarse_mask = 5'b11111;
        xfer7(8'hD2, 0, 0, 0, "R4 bit7 never coarse masked");
        coarse_mask = 5'b00001;
        xfer7(8'h50, 1, 1, 0, "R5 coarse low masks bit1");
        coarse_mask = 5'b00000;
        xfer7(8'h50, 0, 0, 0, "R5 bit1 exact without control");
        full_mask_mode = 1'b1;

        // R2 general call
        gcall_en = 1'b1;
        xfer7(8'h00, 1, 1, 1, "R2 general call enabled");
        gcall_en = 1'b0;
        full_mask = 8'hFF;
        xfer7(8'h00, 0, 0, 0, "R2 general call disabled");
        chk("R2 gcall_hit clear", gcall_hit, 0);
        full_mask = 8'h00;

        // R6 10-bit addressing, own 0x2A5
        ten_bit_mode = 1'b1;
        own_addr = 10'h2A5;
        xfer10(8'hF4, 8'hA5, 1, 1, "R6 ten-bit match");
        xfer10(8'hF2, 8'hA5, 0, 0, "R6 wrong upper bits");
        xfer10(8'hF4, 8'hA4, 1, 0, "R6 second byte mismatch");
        full_mask = 8'h01;
        xfer10(8'hF4, 8'hA4, 1, 1, "R3 mask bit0 in ten-bit");
        full_mask = 8'h00;
        full_mask_mode = 1'b0;
        coarse_mask = 5'b00001;
        xfer10(8'hF4, 8'hA6, 1, 1, "R5 coarse low masks bits1:0");
        coarse_mask = 5'b00000;
        xfer10(8'hF4, 8'hA6, 1, 0, "R5 bits1:0 exact");
        full_mask_mode = 1'b1;
        ten_bit_mode = 1'b0;
        own_addr = 10'h052;

        // R8 repeated start then full address
        i2c_start();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        i2c_start();
        exp_q.push_back(2'b00);
        send_byte(8'h52, got);
        chk("R8 repeated start ack", got, 1);
        i2c_stop();
        chk("R8 repeated start irq", exp_q.size(), 0);

        // R8 stop aborts; remaining bits alone do not complete a match
        i2c_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        i2c_stop();
        scl_m = 1'b0; qwait();
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        read_ack(got);
        chk("R8 no ack after stop", got, 0);
        i2c_stop();

        // R9 / R10 stretch for read and write
        stretch_en = 1'b1;
        for (int d = 0; d < 2; d++) begin
            i2c_start();
            exp_q.push_back({1'b0, d[0]});
            send_byte({7'h29, d[0]}, got);
            chk("R9 stretch ack", got, 1);
            chk("R9 scl held", scl_pull, 1);
            repeat (40) @(negedge clk);
            chk("R9 scl still held", scl_pull, 1);
            stretch_clr = 1'b1;
            @(negedge clk);
            stretch_clr = 1'b0;
            chk("R10 scl released next clock", scl_pull, 0);
            i2c_stop();
        end
        stretch_en = 1'b0;
        i2c_start();
        exp_q.push_back(2'b01);
        send_byte(8'h53, got);
        chk("R9 no-stretch ack", got, 1);
        chk("R9 no hold when disabled", scl_pull, 0);
        i2c_stop();
        chk("R9 irq consumed", exp_q.size(), 0);

        repeat (10) @(negedge clk);
        finish_up();
    end

endmodule